// File: doc/BRIEF.md
# Four-Bit Multi-Function ALU Slice

This block is a purely combinational four-bit arithmetic/logic slice. Two active-high operands, a four-bit function code and a mode bit choose one of 16 bitwise logic functions or one of 16 arithmetic functions. In arithmetic mode an active-low carry input adds one to the result when it is asserted, which gives 32 arithmetic variants. The slice drives a four-bit result, an active-low carry output, an all-ones flag used as an equality test, and active-high group propagate and group generate outputs. Several slices can be chained through the carry pins, or placed side by side with an external lookahead unit that uses the group outputs.

Inside, a small decoder turns the function code and mode into a struct of strobes. The datapath forms two per-bit terms from the operands under those strobes. In arithmetic mode it adds the two terms and the carry. In logic mode it takes the inverted exclusive-or of the two terms.

Top module: `alu_slice4`

## Requirements
- R1: With modeLogic=1, F is a bitwise function of A and B chosen by fnSel. The codes in decimal are: 0 not A, 1 not(A or B), 2 (not A) and B, 3 all zeros, 4 not(A and B), 5 not B, 6 A xor B, 7 A and (not B), 8 (not A) or B, 9 A xnor B, 10 B, 11 A and B, 12 all ones, 13 A or (not B), 14 A or B, 15 A.
- R2: With modeLogic=0 and carryInN=1 (no carry), F is the low four bits of: 0 A, 1 A or B, 2 A or (not B), 3 fifteen (minus one), 4 A + (A and not B), 5 (A or B) + (A and not B), 6 A + (not B) (A minus B minus 1), 7 (A and not B) + 15, 8 A + (A and B), 9 A + B, 10 (A or not B) + (A and B), 11 (A and B) + 15, 12 A + A, 13 (A or B) + A, 14 (A or not B) + A, 15 A + 15 (A minus one).
- R3: With modeLogic=0 and carryInN=0, the value in R2 has one added to it, so code 6 gives A minus B and code 15 gives A.
- R4: Arithmetic results wrap modulo 16. carryOutN is 0 exactly when the full five-bit value from R2 or R3 is 16 or more.
- R5: With modeLogic=1, carryInN has no effect on F. carryOutN is held at 1, and grpProp and grpGen are held at 0.
- R6: allOnes is 1 exactly when all four bits of F are 1, in either mode. With code 6, no carry and A equal to B, this flags equality.
- R7: In arithmetic mode, grpGen is 1 exactly when the R2 value (no carry) is 16 or more.
- R8: In arithmetic mode, grpProp is 1 exactly when the R2 value is exactly 15, so that an incoming carry would ripple out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | Operand A, active high |
| opB | input | 4 | Operand B, active high |
| fnSel | input | 4 | Function code |
| modeLogic | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| carryInN | input | 1 | Carry input, active low |
| resF | output | 4 | Result, active high |
| carryOutN | output | 1 | Carry output, active low |
| allOnes | output | 1 | High when every result bit is 1 |
| grpProp | output | 1 | Group propagate, active high |
| grpGen | output | 1 | Group generate, active high |

## Verification
The slice has no registers, so every output is due in the same cycle as the operands, code, mode and carry that produce it. The bench applies one input combination just after a rising edge and compares all five outputs with its behavioural table at the following falling edge. By then the combinational paths have settled, and no other input change has happened. It walks every combination of mode, code, carry and operands, which covers the wrap, carry and equality corners exhaustively.

// File: rtl/alu_slice4_pkg.sv
package alu_slice4_pkg;

  typedef struct packed {
    logic orB;      // OR-term takes B
    logic orNotB;   // OR-term takes not B
    logic andNotB;  // AND-term takes A and not B
    logic andB;     // AND-term takes A and B
    logic arith;    // arithmetic path active
    logic carry;    // carry injected at bit 0
  } aluStrobes_t;

endpackage

// File: rtl/alu_slice4_ctrl.sv
module alu_slice4_ctrl
  import alu_slice4_pkg::*;
(
  input  logic [3:0]  fnSel,
  input  logic        modeLogic,
  input  logic        carryInN,
  output aluStrobes_t strobes
);

  always_comb begin
    strobes.orB     = fnSel[0];
    strobes.orNotB  = fnSel[1];
    strobes.andNotB = fnSel[2];
    strobes.andB    = fnSel[3];
    strobes.arith   = ~modeLogic;
    strobes.carry   = ~modeLogic & ~carryInN;
  end

  always_comb begin
    // R5
    ctrl_carry_gate_chk: assert (!(strobes.carry && modeLogic))
      else $error("carry strobe raised in logic mode");
  end

endmodule

// File: rtl/alu_slice4_dp.sv
module alu_slice4_dp
  import alu_slice4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] resF,
  output logic             carryOutN,
  output logic             grpProp,
  output logic             grpGen
);

  localparam int SUMW = WIDTH + 1;

  logic [WIDTH-1:0] orTerm, andTerm, bitProp, bitGen;
  logic [WIDTH:0]   carryChain, genAcc, propAcc;

  assign carryChain[0] = strobes.carry;
  assign genAcc[0]     = 1'b0;
  assign propAcc[0]    = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign orTerm[i]  = opA[i] | (opB[i] & strobes.orB) | (~opB[i] & strobes.orNotB);
    assign andTerm[i] = (opA[i] & ~opB[i] & strobes.andNotB) | (opA[i] & opB[i] & strobes.andB);
    assign bitGen[i]  = andTerm[i];
    assign bitProp[i] = orTerm[i] & ~andTerm[i];
    assign carryChain[i+1] = bitGen[i] | (bitProp[i] & carryChain[i]);
    assign genAcc[i+1]     = bitGen[i] | (bitProp[i] & genAcc[i]);
    assign propAcc[i+1]    = bitProp[i] & propAcc[i];
    assign resF[i] = strobes.arith ? (bitProp[i] ^ carryChain[i]) : ~bitProp[i];
  end

  assign grpGen    = strobes.arith & genAcc[WIDTH];
  assign grpProp   = strobes.arith & propAcc[WIDTH];
  assign carryOutN = ~(strobes.arith & (genAcc[WIDTH] | (propAcc[WIDTH] & strobes.carry)));

  logic [SUMW-1:0] refSum;
  always_comb begin
    refSum = SUMW'(orTerm) + SUMW'(andTerm) + SUMW'(strobes.carry);
    if (strobes.arith) begin
      // R4
      sum_carry_match_chk: assert ({~carryOutN, resF} == refSum)
        else $error("lookahead result disagrees with plain sum");
    end
    // R5
    logic_quiet_chk: assert (strobes.arith || (carryOutN && !grpGen && !grpProp))
      else $error("carry or group outputs active in logic mode");
    // R7
    gen_prop_excl_chk: assert (!(grpGen && grpProp))
      else $error("group generate and propagate both high");
    // R8
    prop_fifteen_chk: assert (!grpProp || (SUMW'(orTerm) + SUMW'(andTerm)) == SUMW'((1 << WIDTH) - 1))
      else $error("group propagate without an all-ones partial sum");
  end

endmodule

// File: rtl/alu_slice4.sv
module alu_slice4
  import alu_slice4_pkg::*;
(
  input  logic [3:0] opA,
  input  logic [3:0] opB,
  input  logic [3:0] fnSel,
  input  logic       modeLogic,
  input  logic       carryInN,
  output logic [3:0] resF,
  output logic       carryOutN,
  output logic       allOnes,
  output logic       grpProp,
  output logic       grpGen
);

  aluStrobes_t strobes;

  alu_slice4_ctrl u_ctrl (
    .fnSel     (fnSel),
    .modeLogic (modeLogic),
    .carryInN  (carryInN),
    .strobes   (strobes)
  );

  alu_slice4_dp #(.WIDTH(4)) u_dp (
    .opA       (opA),
    .opB       (opB),
    .strobes   (strobes),
    .resF      (resF),
    .carryOutN (carryOutN),
    .grpProp   (grpProp),
    .grpGen    (grpGen)
  );

  assign allOnes = &resF;

endmodule

// File: tb/alu_slice4_bench.sv
module alu_slice4_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0] opA, opB, fnSel, resF;
  logic modeLogic, carryInN, carryOutN, allOnes, grpProp, grpGen;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  alu_slice4 u_alu_slice4 (
    .opA(opA), .opB(opB), .fnSel(fnSel), .modeLogic(modeLogic), .carryInN(carryInN),
    .resF(resF), .carryOutN(carryOutN), .allOnes(allOnes), .grpProp(grpProp), .grpGen(grpGen)
  );

  function automatic int logicRef(int s, int a, int b);
    int na = 15 - a;
    int nb = 15 - b;
    case (s)
      0: return na;           1: return 15 - (a | b);
      2: return na & b;       3: return 0;
      4: return 15 - (a & b); 5: return nb;
      6: return a ^ b;        7: return a & nb;
      8: return na | b;       9: return 15 - (a ^ b);
      10: return b;           11: return a & b;
      12: return 15;          13: return a | nb;
      14: return a | b;       default: return a;
    endcase
  endfunction

  function automatic int arithRef(int s, int a, int b);
    int nb = 15 - b;
    case (s)
      0: return a;                  1: return a | b;
      2: return a | nb;             3: return 15;
      4: return a + (a & nb);       5: return (a | b) + (a & nb);
      6: return a + nb;             7: return (a & nb) + 15;
      8: return a + (a & b);        9: return a + b;
      10: return (a | nb) + (a & b); 11: return (a & b) + 15;
      12: return a + a;             13: return (a | b) + a;
      14: return (a | nb) + a;      default: return a + 15;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s m=%0d s=%0d cn=%0d a=%0d b=%0d actual=%0d expected=%0d",
               tag, modeLogic, fnSel, carryInN, opA, opB, act, exp);
    end
  endtask

  task automatic applyAndCheck(int m, int s, int cn, int a, int b);
    int base, full, expF, expCo, expP, expG;
    @(posedge clk);
    modeLogic = m[0]; fnSel = s[3:0]; carryInN = cn[0]; opA = a[3:0]; opB = b[3:0];
    @(negedge clk);
    if (m == 1) begin
      expF = logicRef(s, a, b);  // R1, R5 (carry input ignored)
      expCo = 1; expP = 0; expG = 0;
      check(cn == 0 ? "R5 logic F with carry asserted" : "R1 logic F", int'(resF), expF);
      check("R5 logic carry out", int'(carryOutN), expCo);
      check("R5 logic group outputs", int'({grpProp, grpGen}), 0);
    end else begin
      base = arithRef(s, a, b);
      full = base + (cn == 0 ? 1 : 0);
      expF = full % 16;  // R4 wrap
      check(cn == 0 ? "R3 arith F with carry" : "R2 arith F", int'(resF), expF);
      check("R4 carry out", int'(carryOutN), full >= 16 ? 0 : 1);
      check("R7 group generate", int'(grpGen), base >= 16 ? 1 : 0);
      check("R8 group propagate", int'(grpProp), base == 15 ? 1 : 0);
    end
    check("R6 all-ones flag", int'(allOnes), expF == 15 ? 1 : 0);
  endtask

  initial begin
    opA = 4'd0; opB = 4'd0; fnSel = 4'd0; modeLogic = 1'b0; carryInN = 1'b1;
    @(negedge clk);
    // initial settled state: A + nothing = 0, no carry
    check("R2 initial result", int'(resF), 0);
    check("R4 initial carry out", int'(carryOutN), 1);
    // named corners
    applyAndCheck(0, 6, 1, 9, 9);   // R6 equality: A-B-1 with A==B gives 15
    applyAndCheck(0, 6, 0, 9, 4);   // R3 A minus B = 5, carry out low
    applyAndCheck(0, 15, 0, 7, 0);  // R3 code 15 with carry gives A
    applyAndCheck(0, 9, 1, 15, 1);  // R4 wrap 15+1
    applyAndCheck(0, 9, 0, 8, 7);   // R8 propagate with carry
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++)
        for (int cn = 0; cn < 2; cn++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              applyAndCheck(m, s, cn, a, b);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule